// File: doc/BRIEF.md
# Posted-Write Register Synchronizer

This block sits between a simple strobe-based host bus and a set of registers that are used in a slower, unrelated functional clock domain. A host write to one of these synchronized registers is accepted in one bus cycle and queued. Each queued value then crosses into the functional domain through a single request/acknowledge handshake. For every synchronized register the block keeps a pending bit. The bit is set when the write is accepted and cleared once the value has landed. The host reads the bits together as a write-pending mask, which lets it keep writes to several different registers in flight at once.

Writes cross in the same order the host issued them, so a trigger written after a load never lands first. While a register's write is still pending, a further write to it is dropped and a read of it reports an error. An interface control register chooses between posted mode, which is the reset default, and a stalling mode in which the bus waits until the value has landed. The same register can request a soft reset. That reset flushes queued work, clears the functional-side copies and reports completion in a system status bit. One ordinary configuration register is written at once, with no crossing.

Top module: `posted_write_sync`

## Requirements
- R1: After reset the pending mask (offset 0x34) reads 0, the system status bit 0 (offset 0x14) reads 1, the interface control register (offset 0x40) reads 0x4, bus_ready is 1 and every functional-side register is 0.
- R2: The synchronized registers sit at these offsets, each with its pending bit: 0x24 bit 0, 0x28 bit 1, 0x2C bit 2, 0x30 bit 3, 0x38 bit 4, and, when more than five are built, 0x48, 0x4C, 0x50, 0x54, 0x58 on bits 5 to 9. An accepted write sets only that register's bit, visible on the next cycle. The bit clears after the value appears on that register's slice of f_regs, which comes with one f_load_stb pulse.
- R3: A write to a synchronized register whose pending bit is set is dropped. The functional side and later reads keep the earlier value.
- R4: A read of a synchronized register returns the last accepted value. bus_err is 1 in that cycle when its pending bit is set and 0 otherwise.
- R5: The configuration register at 0x10 is written at once. It reads back the new value on the next cycle and never sets a pending bit.
- R6: Accepted writes land in the functional domain one at a time and in the order the host issued them.
- R7: When interface control bit 2 is 0 (stalling mode), a write to a synchronized register holds bus_ready at 0 until the value has landed. When bus_ready returns, the pending mask is 0 and f_regs holds the value.
- R8: A write to interface control with bit 1 set (for example 0x06) starts a soft reset. Status bit 0 reads 0 from the next cycle, and interface control bit 1 reads 1 while the reset is busy. Queued writes are discarded. Shadows and the configuration register clear, and posted mode is restored. Once any transfer already in flight has landed, the functional registers clear with one f_srst_stb pulse. Status bit 0 then returns to 1 with the pending mask at 0.
- R9: Writes to synchronized registers while a soft reset is busy are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low bus-side reset |
| bus_wr | input | 1 | Write strobe, held until bus_ready is 1 |
| bus_rd | input | 1 | Read strobe, data returned in the same cycle |
| bus_addr | input | AW | Byte offset of the accessed register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid while bus_rd is 1 |
| bus_err | output | 1 | Read of a synchronized register with a write pending |
| bus_ready | output | 1 | Access completes on a clock edge where this is 1 |
| fclk | input | 1 | Functional clock |
| f_rst_n | input | 1 | Asynchronous active-low functional-side reset |
| f_regs | output | NUM_SYNC*DW | Functional-domain copies, register i at bits i*DW upward |
| f_load_stb | output | NUM_SYNC | One fclk pulse on the bit of the register that just landed |
| f_srst_stb | output | 1 | One fclk pulse when a soft reset clears the functional copies |

## Verification
The bench builds the block with NUM_SYNC at 7, DW at 32 and AW at 8. This brings the first two optional registers at 0x48 and 0x4C, and pending bits 5 and 6, into the random bursts and the bit-layout check. The functional clock runs several times slower than the bus clock. A burst of up to five back-to-back writes therefore completes before the first value lands, so drops and pending-read errors can be predicted exactly. A landing log taken on the functional side is compared against the host's order of accepted writes.

// File: rtl/pws_pkg.sv
`timescale 1ns/1ps
package pws_pkg;
  localparam int unsigned OFF_CFG   = 'h10;
  localparam int unsigned OFF_SYS   = 'h14;
  localparam int unsigned OFF_WPEND = 'h34;
  localparam int unsigned OFF_IFC   = 'h40;
  localparam int unsigned IFC_SRST_BIT   = 1;
  localparam int unsigned IFC_POSTED_BIT = 2;

  typedef enum logic [1:0] {X_IDLE, X_REQ, X_DROP} xfer_state_e;

  // byte offset of synchronized register i (its pending bit is i)
  function automatic int unsigned sync_off(input int unsigned i);
    if (i < 4)       return 'h24 + 4 * i;
    else if (i == 4) return 'h38;
    else             return 'h48 + 4 * (i - 5);
  endfunction
endpackage

// File: rtl/pws_sync2.sv
`timescale 1ns/1ps
module pws_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      q      <= 1'b0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pws_rst_sync.sv
`timescale 1ns/1ps
module pws_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/pws_fifo.sv
`timescale 1ns/1ps
module pws_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         flush,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wp_d = nxt(wp_q);
      if (pop)  rp_d = nxt(rp_q);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem_q[wp_q] <= din;
  end

  assign dout  = mem_q[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/pws_fside.sv
`timescale 1ns/1ps
module pws_fside #(
  parameter int NUM_SYNC = 5,
  parameter int DW       = 32,
  parameter int IW       = 3
) (
  input  logic                   fclk,
  input  logic                   f_rst_n,
  input  logic                   req,
  input  logic                   kind,
  input  logic [IW-1:0]          idx,
  input  logic [DW-1:0]          data,
  output logic                   ack,
  output logic [NUM_SYNC*DW-1:0] f_regs,
  output logic [NUM_SYNC-1:0]    f_stb,
  output logic                   f_srst_stb
);
  logic                req_s;
  logic                ack_q, ack_d;
  logic [DW-1:0]       regs_q [NUM_SYNC];
  logic [DW-1:0]       regs_d [NUM_SYNC];
  logic [NUM_SYNC-1:0] stb_q, stb_d;
  logic                srst_q, srst_d;

  pws_sync2 u_req_sync (.clk(fclk), .rst_n(f_rst_n), .d(req), .q(req_s));

  always_comb begin
    ack_d  = ack_q;
    regs_d = regs_q;
    stb_d  = '0;
    srst_d = 1'b0;
    if (req_s && !ack_q) begin
      ack_d = 1'b1;
      if (kind) begin
        for (int i = 0; i < NUM_SYNC; i++) regs_d[i] = '0;
        srst_d = 1'b1;
      end else begin
        for (int i = 0; i < NUM_SYNC; i++) begin
          if (idx == IW'(i)) begin
            regs_d[i] = data;
            stb_d[i]  = 1'b1;
          end
        end
      end
    end else if (!req_s && ack_q) begin
      ack_d = 1'b0;
    end
  end

  always_ff @(posedge fclk or negedge f_rst_n) begin
    if (!f_rst_n) begin
      ack_q  <= 1'b0;
      stb_q  <= '0;
      srst_q <= 1'b0;
      for (int i = 0; i < NUM_SYNC; i++) regs_q[i] <= '0;
    end else begin
      ack_q  <= ack_d;
      stb_q  <= stb_d;
      srst_q <= srst_d;
      regs_q <= regs_d;
    end
  end

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_out
    assign f_regs[g*DW +: DW] = regs_q[g];
  end
  assign ack        = ack_q;
  assign f_stb      = stb_q;
  assign f_srst_stb = srst_q;
endmodule

// File: rtl/posted_write_sync.sv
`timescale 1ns/1ps
module posted_write_sync #(
  parameter int NUM_SYNC = 5,
  parameter int DW       = 32,
  parameter int AW       = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  output logic                   bus_err,
  output logic                   bus_ready,
  input  logic                   fclk,
  input  logic                   f_rst_n,
  output logic [NUM_SYNC*DW-1:0] f_regs,
  output logic [NUM_SYNC-1:0]    f_load_stb,
  output logic                   f_srst_stb
);
  import pws_pkg::*;

  localparam int IW = (NUM_SYNC > 1) ? $clog2(NUM_SYNC) : 1;
  localparam int QW = IW + DW;

  logic b_rst_n, fr_rst_n;
  pws_rst_sync u_brst (.clk(clk),  .rst_n(rst_n),   .rst_n_sync(b_rst_n));
  pws_rst_sync u_frst (.clk(fclk), .rst_n(f_rst_n), .rst_n_sync(fr_rst_n));

  // state
  logic [NUM_SYNC-1:0] pend_q, pend_d;
  logic [DW-1:0]       shadow_q [NUM_SYNC];
  logic [DW-1:0]       shadow_d [NUM_SYNC];
  logic [DW-1:0]       cfg_q, cfg_d;
  logic                posted_q, posted_d;
  logic                rst_done_q, rst_done_d;
  logic                srst_pend_q, srst_pend_d;
  logic                hold_q, hold_d;
  logic [IW-1:0]       hold_idx_q, hold_idx_d;
  xfer_state_e         xs_q, xs_d;
  logic                xkind_q, xkind_d;
  logic [IW-1:0]       xidx_q, xidx_d;
  logic [DW-1:0]       xdata_q, xdata_d;

  // decode
  logic          any_hit;
  logic [IW-1:0] hit_idx;
  logic          accept, cfg_wr, ifc_wr, srst_req;
  logic          xreq, ack_s, f_ack;
  logic          pop, fifo_empty, fifo_full;
  logic [QW-1:0] fifo_dout;
  logic [NUM_SYNC-1:0] inflight;

  always_comb begin
    any_hit = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < NUM_SYNC; i++) begin
      if (bus_addr == AW'(sync_off(i))) begin
        any_hit = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  assign accept   = bus_wr && any_hit && !hold_q && !pend_q[hit_idx] && rst_done_q;
  assign cfg_wr   = bus_wr && !hold_q && (bus_addr == AW'(OFF_CFG));
  assign ifc_wr   = bus_wr && !hold_q && (bus_addr == AW'(OFF_IFC));
  assign srst_req = ifc_wr && bus_wdata[IFC_SRST_BIT] && rst_done_q;
  assign xreq     = (xs_q == X_REQ);
  assign inflight = (xreq && !xkind_q) ? (NUM_SYNC'(1) << xidx_q) : '0;

  assign bus_ready = hold_q ? !pend_q[hold_idx_q] : !(accept && !posted_q);

  pws_fifo #(.W(QW), .DEPTH(NUM_SYNC)) u_queue (
    .clk(clk), .rst_n(b_rst_n), .push(accept), .pop(pop), .flush(srst_req),
    .din({hit_idx, bus_wdata}), .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full)
  );

  pws_sync2 u_ack_sync (.clk(clk), .rst_n(b_rst_n), .d(f_ack), .q(ack_s));

  pws_fside #(.NUM_SYNC(NUM_SYNC), .DW(DW), .IW(IW)) u_fside (
    .fclk(fclk), .f_rst_n(fr_rst_n), .req(xreq), .kind(xkind_q), .idx(xidx_q),
    .data(xdata_q), .ack(f_ack), .f_regs(f_regs), .f_stb(f_load_stb),
    .f_srst_stb(f_srst_stb)
  );

  // next state
  always_comb begin
    pend_d      = pend_q;
    shadow_d    = shadow_q;
    cfg_d       = cfg_q;
    posted_d    = posted_q;
    rst_done_d  = rst_done_q;
    srst_pend_d = srst_pend_q;
    hold_d      = hold_q;
    hold_idx_d  = hold_idx_q;
    xs_d        = xs_q;
    xkind_d     = xkind_q;
    xidx_d      = xidx_q;
    xdata_d     = xdata_q;
    pop         = 1'b0;

    unique case (xs_q)
      X_IDLE: begin
        if (srst_pend_q) begin
          xs_d        = X_REQ;
          xkind_d     = 1'b1;
          srst_pend_d = 1'b0;
        end else if (!fifo_empty && !srst_req) begin
          pop               = 1'b1;
          xs_d              = X_REQ;
          xkind_d           = 1'b0;
          {xidx_d, xdata_d} = fifo_dout;
        end
      end
      X_REQ: begin
        if (ack_s) begin
          xs_d = X_DROP;
          if (xkind_q) rst_done_d = 1'b1;
          else         pend_d[xidx_q] = 1'b0;
        end
      end
      X_DROP:  if (!ack_s) xs_d = X_IDLE;
      default: xs_d = X_IDLE;
    endcase

    if (accept) begin
      pend_d[hit_idx]   = 1'b1;
      shadow_d[hit_idx] = bus_wdata;
      if (!posted_q) begin
        hold_d     = 1'b1;
        hold_idx_d = hit_idx;
      end
    end
    if (hold_q && !pend_q[hold_idx_q]) hold_d = 1'b0;
    if (cfg_wr) cfg_d = bus_wdata;
    if (ifc_wr) posted_d = bus_wdata[IFC_POSTED_BIT];

    if (srst_req) begin
      pend_d      = pend_d & inflight;
      for (int i = 0; i < NUM_SYNC; i++) shadow_d[i] = '0;
      cfg_d       = '0;
      posted_d    = 1'b1;
      rst_done_d  = 1'b0;
      srst_pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge b_rst_n) begin
    if (!b_rst_n) begin
      pend_q      <= '0;
      cfg_q       <= '0;
      posted_q    <= 1'b1;
      rst_done_q  <= 1'b1;
      srst_pend_q <= 1'b0;
      hold_q      <= 1'b0;
      hold_idx_q  <= '0;
      xs_q        <= X_IDLE;
      for (int i = 0; i < NUM_SYNC; i++) shadow_q[i] <= '0;
    end else begin
      pend_q      <= pend_d;
      cfg_q       <= cfg_d;
      posted_q    <= posted_d;
      rst_done_q  <= rst_done_d;
      srst_pend_q <= srst_pend_d;
      hold_q      <= hold_d;
      hold_idx_q  <= hold_idx_d;
      xs_q        <= xs_d;
      shadow_q    <= shadow_d;
    end
  end

  // transfer payload: loaded only at launch, held stable while requested
  always_ff @(posedge clk) begin
    if (xs_q == X_IDLE && xs_d == X_REQ) begin
      xkind_q <= xkind_d;
      xidx_q  <= xidx_d;
      xdata_q <= xdata_d;
    end
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    bus_err   = 1'b0;
    if (bus_rd) begin
      if (any_hit) begin
        bus_rdata = shadow_q[hit_idx];
        bus_err   = pend_q[hit_idx];
      end else begin
        case (bus_addr)
          AW'(OFF_CFG):   bus_rdata = cfg_q;
          AW'(OFF_SYS):   bus_rdata[0] = rst_done_q;
          AW'(OFF_WPEND): bus_rdata = DW'(pend_q);
          AW'(OFF_IFC): begin
            bus_rdata[IFC_POSTED_BIT] = posted_q;
            bus_rdata[IFC_SRST_BIT]   = !rst_done_q;
          end
          default:        bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pws_check.sv
`timescale 1ns/1ps
module pws_check #(
  parameter int NUM_SYNC = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fclk,
  input logic                f_rst_n,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic                bus_err,
  input logic [NUM_SYNC-1:0] pend,
  input logic                rst_done,
  input logic                xreq,
  input logic                ack_s,
  input logic                fifo_push,
  input logic                fifo_full,
  input logic [NUM_SYNC-1:0] f_load_stb
);
  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_pend
    AST_PEND_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[g]) |-> $past(bus_wr)); // R2
  end

  AST_ERR_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_rd); // R4

  AST_NO_QUEUE_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !fifo_full); // R3

  AST_REQ_AFTER_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xreq) |-> !ack_s); // R6

  AST_DONE_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_done) |-> $past(bus_wr)); // R8

  AST_ONE_LANDING: assert property (@(posedge fclk) disable iff (!f_rst_n)
    $onehot0(f_load_stb)); // R6
endmodule

bind posted_write_sync pws_check #(.NUM_SYNC(NUM_SYNC)) u_chk (
  .clk(clk), .rst_n(rst_n), .fclk(fclk), .f_rst_n(f_rst_n),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_err(bus_err),
  .pend(pend_q), .rst_done(rst_done_q), .xreq(xreq), .ack_s(ack_s),
  .fifo_push(accept), .fifo_full(fifo_full), .f_load_stb(f_load_stb)
);

// File: tb/posted_write_sync_test.sv
`timescale 1ns/1ps
module posted_write_sync_test;
  localparam int NS = 7;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_CFG = 8'h10, A_SYS = 8'h14, A_WP = 8'h34, A_IFC = 8'h40;

  logic clk = 1'b0, fclk = 1'b0, rst_n = 1'b0, f_rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic bus_err, bus_ready, f_srst_stb;
  logic [NS*DW-1:0] f_regs;
  logic [NS-1:0] f_load_stb;

  always #2 clk = ~clk;
  always #13 fclk = ~fclk;

  posted_write_sync #(.NUM_SYNC(NS), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err), .bus_ready(bus_ready),
    .fclk(fclk), .f_rst_n(f_rst_n), .f_regs(f_regs), .f_load_stb(f_load_stb),
    .f_srst_stb(f_srst_stb)
  );

  int n_chk = 0, n_fail = 0;
  int lg [0:1023];
  int lg_n = 0, srst_cnt = 0;
  logic [DW-1:0] exp_f [NS];

  // landing log on the functional side
  always @(negedge fclk) begin
    for (int i = 0; i < NS; i++) if (f_load_stb[i] && lg_n < 1024) begin lg[lg_n] = i; lg_n++; end
    if (f_srst_stb) srst_cnt++;
  end

  function automatic logic [AW-1:0] off(input int i);
    if (i < 4) return AW'(8'h24 + 4 * i);
    if (i == 4) return 8'h38;
    return AW'(8'h48 + 4 * (i - 5));
  endfunction

  function automatic logic [DW-1:0] fval(input int i);
    return f_regs[i*DW +: DW];
  endfunction

  function automatic logic [DW-1:0] ifc_val(input bit posted, input bit busy);
    return {29'd0, posted, busy, 1'b0};
  endfunction

  task automatic chk(input string req, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_idle();
    bus_wr = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output int stall);
    logic r;
    bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; stall = 0;
    forever begin
      #1 r = bus_ready;
      @(negedge clk);
      if (r) break;
      stall++;
    end
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic e);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata; e = bus_err;
    @(negedge clk);
  endtask

  task automatic drain(input string req);
    logic [DW-1:0] d; logic e;
    for (int k = 0; k < 800; k++) begin
      bus_read(A_WP, d, e);
      if (d == 0) break;
    end
    chk(req, "pending mask drains", d, 0);
    bus_idle();
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] d; logic e; int st;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NS; i++) exp_f[i] = '0;
    #50 rst_n = 1'b1; f_rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R1 reset state
    chk("R1", "ready", {31'd0, bus_ready}, 1);
    bus_read(A_WP, d, e);  chk("R1", "pending mask", d, 0);
    bus_read(A_SYS, d, e); chk("R1", "status bit0", d, 1);
    bus_read(A_IFC, d, e); chk("R1", "ifc", d, ifc_val(1, 0));
    chk("R1", "f_regs zero", {31'd0, f_regs == '0}, 1);

    // R5 immediate register
    bus_write(A_CFG, 32'hC0FFEE01, st);
    bus_read(A_CFG, d, e); chk("R5", "cfg readback", d, 32'hC0FFEE01);
    bus_read(A_WP, d, e);  chk("R5", "no pending", d, 0);

    // R2 bit layout per register
    for (int i = 0; i < NS; i++) begin
      int base;
      base = lg_n;
      bus_write(off(i), 32'h1000 + i, st);
      bus_read(A_WP, d, e); chk("R2", $sformatf("pending bit reg %0d", i), d, 32'(1) << i);
      drain("R2");
      exp_f[i] = 32'h1000 + i;
      chk("R2", $sformatf("landed value reg %0d", i), fval(i), exp_f[i]);
      chk("R2", $sformatf("one strobe reg %0d", i), lg_n - base, 1);
    end

    // R3 directed drop
    bus_write(off(1), 32'hAAAA, st);
    bus_write(off(1), 32'hBBBB, st);
    bus_read(off(1), d, e); chk("R4", "err while pending", {31'd0, e}, 1);
    drain("R3");
    exp_f[1] = 32'hAAAA;
    chk("R3", "f keeps first", fval(1), 32'hAAAA);
    bus_read(off(1), d, e); chk("R3", "shadow keeps first", d, 32'hAAAA);
    chk("R4", "no err after landing", {31'd0, e}, 0);

    // R6 directed load then trigger
    begin
      int base;
      base = lg_n;
      bus_write(off(2), 32'h111, st);
      bus_write(off(3), 32'h0, st);
      drain("R6");
      exp_f[2] = 32'h111; exp_f[3] = 32'h0;
      chk("R6", "first landing is load", lg[base], 2);
      chk("R6", "second landing is trigger", lg[base + 1], 3);
    end

    // random bursts: R3 R4 R6
    for (int r = 0; r < 25; r++) begin
      int nb, ne, base, first;
      int eo [8];
      logic [NS-1:0] seen;
      nb = 1 + int'($urandom % 5); ne = 0; seen = '0; base = lg_n; first = 0;
      for (int b = 0; b < nb; b++) begin
        int idx; logic [DW-1:0] v;
        idx = int'($urandom % NS); v = $urandom;
        bus_write(off(idx), v, st);
        if (!seen[idx]) begin
          seen[idx] = 1'b1; exp_f[idx] = v; eo[ne] = idx;
          if (ne == 0) first = idx;
          ne++;
        end
      end
      bus_read(off(first), d, e); chk("R4", "err during burst", {31'd0, e}, 1);
      drain("R6");
      chk("R6", "landing count", lg_n - base, ne);
      for (int k = 0; k < ne; k++) chk("R6", "landing order", lg[base + k], eo[k]);
      for (int i = 0; i < NS; i++) begin
        chk("R3", $sformatf("f value reg %0d", i), fval(i), exp_f[i]);
        bus_read(off(i), d, e);
        chk("R4", "shadow readback", d, exp_f[i]);
        chk("R4", "no err when idle", {31'd0, e}, 0);
      end
    end

    // R7 stalling mode
    bus_write(A_IFC, 32'h0, st);
    bus_read(A_IFC, d, e); chk("R7", "ifc stalling", d, ifc_val(0, 0));
    bus_write(off(4), 32'h5A5A, st);
    chk("R7", "write stalled", {31'd0, st > 2}, 1);
    chk("R7", "landed at completion", fval(4), 32'h5A5A);
    bus_read(A_WP, d, e); chk("R7", "nothing pending", d, 0);
    exp_f[4] = 32'h5A5A;
    bus_write(A_IFC, 32'h4, st);
    bus_idle();

    // R8 R9 soft reset
    begin
      int sc;
      sc = srst_cnt;
      bus_write(A_CFG, 32'h77, st);
      for (int i = 0; i < 4; i++) bus_write(off(i), 32'h900 + i, st);
      bus_write(A_IFC, 32'h6, st);
      bus_read(A_SYS, d, e); chk("R8", "status busy", d, 0);
      bus_read(A_IFC, d, e); chk("R8", "ifc busy", d, ifc_val(1, 1));
      bus_write(off(4), 32'hDEAD, st);
      for (int k = 0; k < 800; k++) begin
        bus_read(A_SYS, d, e);
        if (d[0]) break;
      end
      chk("R8", "status done", d, 1);
      bus_idle();
      repeat (20) @(negedge clk);
      bus_read(A_WP, d, e);  chk("R8", "pending cleared", d, 0);
      chk("R8", "f_regs cleared", {31'd0, f_regs == '0}, 1);
      chk("R8", "one reset pulse", srst_cnt - sc, 1);
      bus_read(A_CFG, d, e); chk("R8", "cfg cleared", d, 0);
      bus_read(A_IFC, d, e); chk("R8", "posted restored", d, ifc_val(1, 0));
      bus_read(off(4), d, e);
      chk("R9", "dropped write shadow", d, 0);
      chk("R9", "dropped write f side", fval(4), 0);
      bus_idle();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule